// File: doc/BRIEF.md
# Signed Bidirectional Barrel Shifter

A purely combinational shift unit. A data operand `a_i` is widened to an internal width, shifted by an amount `b_i` under the control of a 3-bit opcode, and truncated to the result width to give `y_o`. Each operand carries its own signedness flag. The flag on `a_i` picks sign or zero extension. The flag on `b_i` matters only in the two direction-by-sign opcodes, where a negative amount turns the shift to the left.

The part-select opcode behaves like the direction-by-sign shift, except that positions with no source bit are reported as undefined. This is done through `y_valid_o`, a mask with one bit per result bit that is cleared wherever the value is undefined. The data bits at those positions are driven to zero. For every other opcode the mask is all ones.

The internal width is the larger of the operand width and the result width. An operand wider than the result is therefore shifted at full width before truncation.

Top module: `barrel_shift`

## Requirements
- R1: Opcode 3'b000 shifts the extended operand left by the unsigned amount and fills vacated low bits with 0.
- R2: Opcode 3'b010 (arithmetic left) yields exactly the same `y_o` as opcode 3'b000 for every input.
- R3: Opcode 3'b001 shifts right by the unsigned amount and fills vacated high bits with 0.
- R4: Opcode 3'b011 shifts right by the unsigned amount. Vacated high bits take bit `A_W-1` of `a_i` when `a_signed_i`=1, and 0 otherwise.
- R5: For opcodes 3'b000 to 3'b011, `b_signed_i` has no effect: `b_i` is always read as unsigned.
- R6: Opcode 3'b100 shifts right logically when `b_signed_i`=0 or `b_i` is non-negative. With `b_signed_i`=1 and bit `B_W-1` of `b_i` set, it shifts left by the two's-complement magnitude of `b_i`.
- R7: Opcode 3'b101 uses the direction and amount rules of R6. At every result position whose source index falls outside the extended operand, `y_valid_o` is 0 and `y_o` is 0. At all other positions `y_valid_o` is 1.
- R8: The operand is sign-extended when `a_signed_i`=1 and zero-extended when `a_signed_i`=0, in both cases to max(`A_W`,`Y_W`) bits before shifting.
- R9: A shift magnitude at or above max(`A_W`,`Y_W`) yields all fill bits. For opcode 3'b101 it yields `y_valid_o` = 0.
- R10: For every opcode other than 3'b101, `y_valid_o` is all ones. Opcodes 3'b110 and 3'b111 give `y_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | A_W | Data operand |
| a_signed_i | input | 1 | Data operand is signed |
| b_i | input | B_W | Shift amount |
| b_signed_i | input | 1 | Shift amount is signed (opcodes 3'b100 and 3'b101 only) |
| op_i | input | 3 | Shift opcode |
| y_o | output | Y_W | Shift result |
| y_valid_o | output | Y_W | Per-bit defined mask, 0 where the result is undefined |

## Verification
The checks are sampled when the inputs are steady. They assume that all five inputs change together and are fully known, with no X or Z bits, since the block has no clock and its mask logic reads every input. The stimulus drives complete input vectors at one instant, away from the bench clock edge, and samples only after they have settled. It draws amounts across the whole `b_i` range, so overflow magnitudes, the most negative signed amount and the two unused opcodes all occur alongside directed vectors.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;

  typedef enum logic [2:0] {
    OP_SHL    = 3'b000,
    OP_SHR    = 3'b001,
    OP_SSHL   = 3'b010,
    OP_SSHR   = 3'b011,
    OP_SHIFT  = 3'b100,
    OP_SHIFTX = 3'b101
  } shift_op_e;

  function automatic int max_int(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/bsh_ext.sv
module bsh_ext #(
  parameter int A_W = 16,
  parameter int W   = 24
) (
  input  logic [A_W-1:0] a_i,
  input  logic           signed_i,
  output logic [W-1:0]   a_o
);
  logic sign;
  assign sign = signed_i & a_i[A_W-1];

  generate
    if (W > A_W) begin : g_widen
      assign a_o = {{(W-A_W){sign}}, a_i};
    end else begin : g_same
      assign a_o = a_i;
    end
  endgenerate
endmodule

// File: rtl/bsh_amt_dec.sv
module bsh_amt_dec
  import barrel_shift_pkg::*;
#(
  parameter int B_W  = 5,
  parameter int W    = 24,
  parameter int SH_W = 5
) (
  input  logic [B_W-1:0]  b_i,
  input  logic            b_signed_i,
  input  logic [2:0]      op_i,
  output logic            left_o,
  output logic            arith_o,
  output logic            partsel_o,
  output logic            kill_o,
  output logic [SH_W-1:0] amt_o
);
  localparam int MW = max_int(B_W + 1, SH_W + 1);

  logic           dir_mode, neg;
  logic [B_W:0]   mag;
  logic [MW-1:0]  mag_w;

  assign dir_mode = (op_i == OP_SHIFT) || (op_i == OP_SHIFTX);
  // plain opcodes never honour the amount sign
  assign neg      = dir_mode & b_signed_i & b_i[B_W-1];
  assign mag      = neg ? (~{b_i[B_W-1], b_i} + 1'b1) : {1'b0, b_i};
  assign mag_w    = MW'(mag);

  always_comb begin
    left_o    = 1'b0;
    arith_o   = 1'b0;
    partsel_o = 1'b0;
    kill_o    = 1'b0;
    unique case (op_i)
      OP_SHL, OP_SSHL:    left_o = 1'b1;
      OP_SHR:             left_o = 1'b0;
      OP_SSHR:            arith_o = 1'b1;
      OP_SHIFT:           left_o = neg;
      OP_SHIFTX: begin
        left_o    = neg;
        partsel_o = 1'b1;
      end
      default:            kill_o = 1'b1;
    endcase
  end

  // clamp so one saturating stage covers any overflow
  assign amt_o = (mag_w >= MW'(W)) ? SH_W'(W) : SH_W'(mag_w);
endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
  parameter int W    = 24,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    data_i,
  input  logic            left_i,
  input  logic            fill_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    data_o
);
  logic [SH_W:0][W-1:0] st;
  logic [W-1:0]         rev_in, rev_out;
  logic                 fill;

  assign fill = fill_i & ~left_i;

  always_comb begin
    for (int i = 0; i < W; i++) rev_in[i] = data_i[W-1-i];
  end

  // left shift = reversed right shift with zero fill
  assign st[0] = left_i ? rev_in : data_i;

  generate
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int K = ((1 << s) < W) ? (1 << s) : W;
      if (K < W) begin : g_part
        assign st[s+1] = amt_i[s] ? {{K{fill}}, st[s][W-1:K]} : st[s];
      end else begin : g_full
        assign st[s+1] = amt_i[s] ? {W{fill}} : st[s];
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < W; i++) rev_out[i] = st[SH_W][W-1-i];
  end

  assign data_o = left_i ? rev_out : st[SH_W];
endmodule

// File: rtl/barrel_shift.sv
module barrel_shift
  import barrel_shift_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 5,
  parameter int Y_W = 24
) (
  input  logic [A_W-1:0] a_i,
  input  logic           a_signed_i,
  input  logic [B_W-1:0] b_i,
  input  logic           b_signed_i,
  input  logic [2:0]     op_i,
  output logic [Y_W-1:0] y_o,
  output logic [Y_W-1:0] y_valid_o
);
  localparam int W    = max_int(A_W, Y_W);
  localparam int SH_W = $clog2(W + 1);
  localparam int NL   = 2;  // lane 0: data, lane 1: defined mask

  logic [W-1:0]    a_ext;
  logic            left, arith, partsel, kill;
  logic [SH_W-1:0] amt;
  logic [NL-1:0][W-1:0] lane_in, lane_out;
  logic [NL-1:0]        lane_fill;

  bsh_ext #(.A_W(A_W), .W(W)) u_ext (
    .a_i      (a_i),
    .signed_i (a_signed_i),
    .a_o      (a_ext)
  );

  bsh_amt_dec #(.B_W(B_W), .W(W), .SH_W(SH_W)) u_dec (
    .b_i        (b_i),
    .b_signed_i (b_signed_i),
    .op_i       (op_i),
    .left_o     (left),
    .arith_o    (arith),
    .partsel_o  (partsel),
    .kill_o     (kill),
    .amt_o      (amt)
  );

  assign lane_in[0]   = a_ext;
  assign lane_fill[0] = arith & a_signed_i & a_i[A_W-1];
  assign lane_in[1]   = '1;
  assign lane_fill[1] = 1'b0;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_lane
      bsh_core #(.W(W), .SH_W(SH_W)) u_core (
        .data_i (lane_in[l]),
        .left_i (left),
        .fill_i (lane_fill[l]),
        .amt_i  (amt),
        .data_o (lane_out[l])
      );
    end
  endgenerate

  assign y_valid_o = partsel ? lane_out[1][Y_W-1:0] : '1;
  assign y_o       = kill ? '0 : (lane_out[0][Y_W-1:0] & y_valid_o);
endmodule

// File: rtl/barrel_shift_chk.sv
module barrel_shift_chk
  import barrel_shift_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 5,
  parameter int Y_W = 24
) (
  input logic [A_W-1:0] a_i,
  input logic           a_signed_i,
  input logic [B_W-1:0] b_i,
  input logic           b_signed_i,
  input logic [2:0]     op_i,
  input logic [Y_W-1:0] y_o,
  input logic [Y_W-1:0] y_valid_o
);
  localparam int W = max_int(A_W, Y_W);

  logic big_amt;
  assign big_amt = 32'(b_i) >= W;

  always_comb begin
    // R10
    valid_ones_chk: assert (op_i == OP_SHIFTX || y_valid_o == '1);
    // R7
    undef_zero_chk: assert ((y_o & ~y_valid_o) == '0);
    // R10
    if (op_i == 3'b110 || op_i == 3'b111)
      unused_op_chk: assert (y_o == '0);
    // R9
    if (op_i == OP_SHR && big_amt)
      shr_ovf_chk: assert (y_o == '0);
    // R4
    if (op_i == OP_SSHR && big_amt && a_signed_i && a_i[A_W-1])
      sshr_ovf_chk: assert (y_o == '1);
    // R9
    if (op_i == OP_SHIFTX && big_amt && !(b_signed_i && b_i[B_W-1]))
      partsel_ovf_chk: assert (y_valid_o == '0);
  end
endmodule

bind barrel_shift barrel_shift_chk #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_chk (.*);

// File: tb/barrel_shift_bench.sv
module barrel_shift_bench;
  localparam int A_W = 16;
  localparam int B_W = 5;
  localparam int Y_W = 24;
  localparam int W   = (A_W > Y_W) ? A_W : Y_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [A_W-1:0] a;
  logic           as;
  logic [B_W-1:0] b;
  logic           bs;
  logic [2:0]     op;
  logic [Y_W-1:0] y, yv;

  int n_cmp = 0;
  int n_bad = 0;

  barrel_shift #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_barrel_shift (
    .a_i(a), .a_signed_i(as), .b_i(b), .b_signed_i(bs), .op_i(op),
    .y_o(y), .y_valid_o(yv)
  );

  function automatic logic ext_bit(int j);
    if (j < A_W) return a[j];
    return as & a[A_W-1];
  endfunction

  // reference: returns {valid, data}
  function automatic logic [2*Y_W-1:0] ref_model();
    logic [Y_W-1:0] ry, rv;
    int  amt;
    bit  lft, px, sfill;
    ry = '0; rv = '1;
    amt = int'(b); lft = 0; px = 0; sfill = 0;
    case (op)
      3'b000, 3'b010: lft = 1;
      3'b001: lft = 0;
      3'b011: sfill = as & a[A_W-1];
      3'b100, 3'b101: begin
        px = (op == 3'b101);
        if (bs && b[B_W-1]) begin
          lft = 1;
          amt = (1 << B_W) - int'(b);
        end
      end
      default: return {{Y_W{1'b1}}, {Y_W{1'b0}}};
    endcase
    for (int i = 0; i < Y_W; i++) begin
      int src;
      src = lft ? i - amt : i + amt;
      if (src < 0 || src >= W) begin
        ry[i] = (!lft && !px) ? sfill : 1'b0;
        rv[i] = !px;
      end else begin
        ry[i] = ext_bit(src);
      end
    end
    return {rv, ry};
  endfunction

  task automatic apply(input logic [A_W-1:0] ta, input logic tas,
                       input logic [B_W-1:0] tb, input logic tbs,
                       input logic [2:0] top);
    @(negedge clk);
    a = ta; as = tas; b = tb; bs = tbs; op = top;
    #1;
  endtask

  task automatic check(input string tag);
    logic [2*Y_W-1:0] e;
    e = ref_model();
    n_cmp++;
    if (y !== e[Y_W-1:0] || yv !== e[2*Y_W-1:Y_W]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h as=%0d b=%h bs=%0d: y=%h/v=%h expected y=%h/v=%h",
               tag, op, a, as, b, bs, y, yv, e[Y_W-1:0], e[2*Y_W-1:Y_W]);
    end
  endtask

  task automatic check_val(input string tag, input logic [Y_W-1:0] got,
                           input logic [Y_W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R3";
      3'b010: return "R2";
      3'b011: return "R4";
      3'b100: return "R6";
      3'b101: return "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [Y_W-1:0] y_ref;
    void'($urandom(32'h5eed_0017));
    a = '0; as = 0; b = '0; bs = 0; op = '0;
    #1;
    // R10 idle inputs
    check_val("R10 idle y", y, '0);
    check_val("R10 idle valid", yv, '1);

    // R1 left by 4
    apply(16'h8001, 1'b0, 5'd4, 1'b0, 3'b000);
    check_val("R1 shl", y, 24'h080010);
    // R2 arithmetic left matches logical left
    y_ref = y;
    apply(16'h8001, 1'b0, 5'd4, 1'b0, 3'b010);
    check_val("R2 sshl==shl", y, y_ref);
    // R8 sign extension then right shift logically
    apply(16'h8000, 1'b1, 5'd4, 1'b0, 3'b001);
    check_val("R8 R3 shr signed A", y, 24'h0FF800);
    apply(16'h8000, 1'b0, 5'd4, 1'b0, 3'b001);
    check_val("R8 shr unsigned A", y, 24'h000800);
    // R4 arithmetic right
    apply(16'h8000, 1'b1, 5'd30, 1'b0, 3'b011);
    check_val("R4 sshr signed ovf", y, 24'hFFFFFF);
    apply(16'h8000, 1'b0, 5'd30, 1'b0, 3'b011);
    check_val("R4 sshr unsigned ovf", y, 24'h000000);
    // R5 amount flagged signed is still unsigned here: 5'h1F = 31
    apply(16'hFFFF, 1'b0, 5'h1F, 1'b1, 3'b000);
    check_val("R5 shl ignores b sign", y, 24'h000000);
    apply(16'h00F0, 1'b0, 5'h11, 1'b1, 3'b001);
    check_val("R5 shr ignores b sign", y, 24'h000000);
    // R6 negative amount -> left by 2
    apply(16'h0003, 1'b0, 5'h1E, 1'b1, 3'b100);
    check_val("R6 shift neg", y, 24'h00000C);
    apply(16'h0300, 1'b0, 5'h1E, 1'b0, 3'b100);
    check_val("R6 shift unsigned", y, 24'h000000);
    // R7 part-select right by 8, top 8 undefined
    apply(16'hABCD, 1'b1, 5'd8, 1'b0, 3'b101);
    check_val("R7 shiftx data", y, 24'h00FFAB);
    check_val("R7 shiftx valid", yv, 24'h00FFFF);
    // R9 part-select overflow, most negative amount left by 16
    apply(16'h1234, 1'b0, 5'd24, 1'b0, 3'b101);
    check_val("R9 shiftx ovf valid", yv, 24'h000000);
    apply(16'h1234, 1'b0, 5'h10, 1'b1, 3'b101);
    check_val("R9 R7 shiftx -16 data", y, 24'h340000);
    check_val("R9 R7 shiftx -16 valid", yv, 24'hFF0000);
    // R10 unused opcodes
    apply(16'hFFFF, 1'b1, 5'd0, 1'b0, 3'b111);
    check_val("R10 op7 y", y, '0);
    check_val("R10 op7 valid", yv, '1);

    for (int k = 0; k < 4000; k++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      apply(A_W'($urandom), 1'($urandom), B_W'($urandom), 1'($urandom), ro);
      check(tag_of(ro));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule